// File: doc/BRIEF.md
# Dual-Port Four-Channel Mailbox

This block links two processors, called side A and side B, through four word-wide channels in each direction. Each side has its own synchronous register bus with a word address, a write strobe, a read strobe, write data and combinational read data. When a side writes one of its four transmit words, the value is latched into a slot that the other side reads as the receive word with the same channel number. A single flag per slot drives both views of the channel. One side sees it as "transmit slot empty" and the other side sees it as "receive slot full", so the handshake cannot drift between the two sides.

A status word on each side reports the channel flags and the incoming doorbell requests, with channel 0 in the highest bit of each field. A control word holds per-channel enables for the receive, transmit and doorbell interrupt sources, plus three free flag bits. Writing a 1 to a doorbell bit in the control word raises a pending doorbell on the peer side. The peer acknowledges it by writing a 1 to the matching status bit. Each side has one level interrupt output and one sticky overrun output.

Word addresses are as follows: transmit channels at 0 to 3, receive channels at 4 to 7, status at 8 and control at 9. In all fields below, channel n sits at the top bit of the field minus n.

Top module: `mbx_top`

## Requirements
- R1: After reset, status reads 0x00F00000 on both sides (every transmit-empty bit set, every receive-full bit and every doorbell bit clear). Control and all receive words read 0, and both irq and overrun outputs are 0.
- R2: A write to transmit word n on one side stores the data for the peer. From the next cycle, the writer's status bit 23−n reads 0 and the peer's status bit 27−n reads 1.
- R3: A read of receive word n returns the stored data in the same cycle. From the next cycle, the reader's status bit 27−n reads 0 and the peer's status bit 23−n reads 1.
- R4: The two directions are independent: traffic from B to A uses the same rules and leaves the A-to-B slots untouched.
- R5: Control fields read back as written: receive/transmit/doorbell enables in [27:24]/[23:20]/[31:28] and flags in [2:0]. The doorbell field [19:16] reads back the peer's pending doorbells.
- R6: Writing 1 to control bit 19−n sets pending doorbell n on the peer, visible at its status bit 19−n. The peer clears it by writing 1 to that status bit. Writing 0 there leaves it pending.
- R7: irq is high exactly when some channel has (receive-full and receive enable), (transmit-empty and transmit enable) or (pending doorbell and doorbell enable). Bits are matched by channel.
- R8: A write to a transmit word whose slot is still full replaces the data, keeps the slot full and sets that side's overrun output. Overrun then stays high until reset.
- R9: If a slot is written and read in the same cycle, the read returns the old data and the slot ends full with the new data. No overrun is flagged.
- R10: If a doorbell is raised and acknowledged in the same cycle, it stays pending.
- R11: Transmit words read as 0. Writes to receive words have no effect. Writes to status change only doorbell bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| a_addr | input | 4 | Side A word address |
| a_we | input | 1 | Side A write strobe |
| a_re | input | 1 | Side A read strobe |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data (same cycle) |
| a_irq | output | 1 | Side A interrupt |
| a_ovr | output | 1 | Side A sticky overrun |
| b_addr | input | 4 | Side B word address |
| b_we | input | 1 | Side B write strobe |
| b_re | input | 1 | Side B read strobe |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data (same cycle) |
| b_irq | output | 1 | Side B interrupt |
| b_ovr | output | 1 | Side B sticky overrun |

## Verification
Two pairs of functions can land in one cycle. The first pair is a producer writing a channel while the consumer reads that same channel. The second pair is a doorbell being raised on one side while the other side acknowledges it. The bench drives both sides' buses in a single cycle to provoke each case. For the slot collision it checks that the old word was returned, that the flag is full again, that the new word follows, and that no overrun was flagged. For the doorbell collision it checks that the pending bit survives the acknowledge.

// File: rtl/mbx_pkg.sv
// Shared constants for the mailbox: map indices and field top bits.
// Assumes four channels, so that each field fills one nibble.
package mbx_pkg;
    localparam int NCH      = 4;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int FLAG_W   = 3;
    // Field top bits; channel n sits at TOP - n
    localparam int GIE_TOP  = 31;
    localparam int RIE_TOP  = 27;
    localparam int TIE_TOP  = 23;
    localparam int GIR_TOP  = 19;
    localparam int RXF_TOP  = 27;
    localparam int TXE_TOP  = 23;
    localparam int PND_TOP  = 19;
endpackage

// File: rtl/mbx_slot.sv
// One channel in one direction: data word plus the shared full flag.
// Writer side sees !full as transmit-empty, reader side sees full.
// Assumes a write wins over a same-cycle read.
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ovr_o
);
    // Latch data and update the full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            full_o <= 1'b0;
        end else if (wr_i) begin
            data_o <= wdata_i;
            full_o <= 1'b1;
        end else if (rd_i) begin
            full_o <= 1'b0;
        end
    end

    // Overrun: write onto a full slot that is not being drained now
    assign ovr_o = wr_i & full_o & ~rd_i;
endmodule

// File: rtl/mbx_port.sv
// Register front end for one side: decode, control word, pending
// doorbells, status assembly, read mux, irq and sticky overrun.
// Assumes NCH is a power of two and at most four.
module mbx_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = mbx_pkg::DATA_W,
    parameter int NCH    = mbx_pkg::NCH,
    parameter int ADDR_W = mbx_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              ovr_o,
    input  logic [NCH-1:0]    tx_full_i,
    input  logic [NCH-1:0]    tx_ovr_i,
    input  logic [NCH-1:0]    rx_full_i,
    input  logic [DATA_W-1:0] rx_data_i [NCH],
    input  logic [NCH-1:0]    peer_gir_i,
    input  logic [NCH-1:0]    peer_pend_i,
    output logic [NCH-1:0]    tx_wr_o,
    output logic [NCH-1:0]    rx_rd_o,
    output logic [NCH-1:0]    gir_o,
    output logic [NCH-1:0]    pend_o
);
    localparam int SEL_W    = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int STAT_IDX = 2 * NCH;
    localparam int CTRL_IDX = 2 * NCH + 1;

    logic [NCH-1:0]    gie_q, rie_q, tie_q;
    logic [FLAG_W-1:0] flag_q;
    logic              stat_wr, ctrl_wr;
    logic [NCH-1:0]    ack;
    logic [DATA_W-1:0] stat_w, ctrl_w;
    logic [SEL_W-1:0]  rx_sel;
    logic              unused_wbits;

    assign stat_wr      = we_i && (addr_i == ADDR_W'(STAT_IDX));
    assign ctrl_wr      = we_i && (addr_i == ADDR_W'(CTRL_IDX));
    assign rx_sel       = addr_i[SEL_W-1:0];
    assign unused_wbits = ^{wdata_i[15:FLAG_W]};

    // Per-channel strobes, doorbell pulses and acknowledges
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            tx_wr_o[n] = we_i && (addr_i == ADDR_W'(n));
            rx_rd_o[n] = re_i && (addr_i == ADDR_W'(NCH + n));
            gir_o[n]   = ctrl_wr && wdata_i[GIR_TOP-n];
            ack[n]     = stat_wr && wdata_i[PND_TOP-n];
        end
    end

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= '0;
            rie_q  <= '0;
            tie_q  <= '0;
            flag_q <= '0;
        end else if (ctrl_wr) begin
            for (int n = 0; n < NCH; n++) begin
                gie_q[n] <= wdata_i[GIE_TOP-n];
                rie_q[n] <= wdata_i[RIE_TOP-n];
                tie_q[n] <= wdata_i[TIE_TOP-n];
            end
            flag_q <= wdata_i[FLAG_W-1:0];
        end
    end

    // Pending doorbells: raise from peer wins over local acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= peer_gir_i | (pend_o & ~ack);
    end

    // Assemble status and control words in descending channel order
    always_comb begin
        stat_w = '0;
        ctrl_w = '0;
        for (int n = 0; n < NCH; n++) begin
            stat_w[RXF_TOP-n] = rx_full_i[n];
            stat_w[TXE_TOP-n] = ~tx_full_i[n];
            stat_w[PND_TOP-n] = pend_o[n];
            ctrl_w[GIE_TOP-n] = gie_q[n];
            ctrl_w[RIE_TOP-n] = rie_q[n];
            ctrl_w[TIE_TOP-n] = tie_q[n];
            ctrl_w[GIR_TOP-n] = peer_pend_i[n];
        end
        ctrl_w[FLAG_W-1:0] = flag_q;
    end

    // Read mux; transmit words read as zero
    always_comb begin
        if (addr_i >= ADDR_W'(NCH) && addr_i < ADDR_W'(2 * NCH))
            rdata_o = rx_data_i[rx_sel];
        else if (addr_i == ADDR_W'(STAT_IDX))
            rdata_o = stat_w;
        else if (addr_i == ADDR_W'(CTRL_IDX))
            rdata_o = ctrl_w;
        else
            rdata_o = '0;
    end

    // Interrupt combine
    assign irq_o = |(rx_full_i & rie_q) | |(~tx_full_i & tie_q) | |(pend_o & gie_q);

    // Sticky overrun
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_o <= 1'b0;
        else if (|tx_ovr_i) ovr_o <= 1'b1;
    end
endmodule

// File: rtl/mbx_top.sv
// Two-sided mailbox: two register front ends and 2*NCH channel slots.
// Assumes both sides share one clock; no clock-domain crossing inside.
module mbx_top
    import mbx_pkg::*;
#(
    parameter int DATA_W = mbx_pkg::DATA_W,
    parameter int NCH    = mbx_pkg::NCH,
    parameter int ADDR_W = mbx_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_we,
    input  logic              a_re,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq,
    output logic              a_ovr,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq,
    output logic              b_ovr
);
    logic [NCH-1:0]    ab_full, ab_ovr, ba_full, ba_ovr;
    logic [DATA_W-1:0] ab_data [NCH];
    logic [DATA_W-1:0] ba_data [NCH];
    logic [NCH-1:0]    a_txwr, a_rxrd, b_txwr, b_rxrd;
    logic [NCH-1:0]    a_gir, b_gir, a_pend, b_pend;

    // Channel slots for both directions
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mbx_slot #(.DATA_W(DATA_W)) u_ab (
            .clk(clk), .rst_n(rst_n), .wr_i(a_txwr[n]), .rd_i(b_rxrd[n]),
            .wdata_i(a_wdata), .data_o(ab_data[n]), .full_o(ab_full[n]),
            .ovr_o(ab_ovr[n]));
        mbx_slot #(.DATA_W(DATA_W)) u_ba (
            .clk(clk), .rst_n(rst_n), .wr_i(b_txwr[n]), .rd_i(a_rxrd[n]),
            .wdata_i(b_wdata), .data_o(ba_data[n]), .full_o(ba_full[n]),
            .ovr_o(ba_ovr[n]));
    end

    mbx_port #(.DATA_W(DATA_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_pa (
        .clk(clk), .rst_n(rst_n), .addr_i(a_addr), .we_i(a_we), .re_i(a_re),
        .wdata_i(a_wdata), .rdata_o(a_rdata), .irq_o(a_irq), .ovr_o(a_ovr),
        .tx_full_i(ab_full), .tx_ovr_i(ab_ovr), .rx_full_i(ba_full),
        .rx_data_i(ba_data), .peer_gir_i(b_gir), .peer_pend_i(b_pend),
        .tx_wr_o(a_txwr), .rx_rd_o(a_rxrd), .gir_o(a_gir), .pend_o(a_pend));

    mbx_port #(.DATA_W(DATA_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_pb (
        .clk(clk), .rst_n(rst_n), .addr_i(b_addr), .we_i(b_we), .re_i(b_re),
        .wdata_i(b_wdata), .rdata_o(b_rdata), .irq_o(b_irq), .ovr_o(b_ovr),
        .tx_full_i(ba_full), .tx_ovr_i(ba_ovr), .rx_full_i(ab_full),
        .rx_data_i(ab_data), .peer_gir_i(a_gir), .peer_pend_i(a_pend),
        .tx_wr_o(b_txwr), .rx_rd_o(b_rxrd), .gir_o(b_gir), .pend_o(b_pend));
endmodule

// File: rtl/mbx_chk.sv
// Property checker for the A-to-B direction and B-side doorbells,
// bound into mbx_top.
module mbx_chk #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_we,
    input logic [NCH-1:0]    a_gir_bits,
    input logic              a_ovr,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_we,
    input logic              b_re,
    input logic [NCH-1:0]    b_ack_bits,
    input logic [NCH-1:0]    ab_full,
    input logic [NCH-1:0]    b_pend
);
    localparam int STAT_IDX = 2 * NCH;
    localparam int CTRL_IDX = 2 * NCH + 1;

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ovr |=> a_ovr);

    for (genvar n = 0; n < NCH; n++) begin : g_p
        // R2
        tx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_we && a_addr == ADDR_W'(n)) |=> ab_full[n]);
        // R3
        rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (b_re && b_addr == ADDR_W'(NCH + n) && !(a_we && a_addr == ADDR_W'(n)))
            |=> !ab_full[n]);
        // R8
        ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_we && a_addr == ADDR_W'(n) && ab_full[n]
             && !(b_re && b_addr == ADDR_W'(NCH + n))) |=> a_ovr);
        // R10
        bell_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_we && a_addr == ADDR_W'(CTRL_IDX) && a_gir_bits[NCH-1-n])
            |=> b_pend[n]);
        // R6
        bell_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (b_we && b_addr == ADDR_W'(STAT_IDX) && b_ack_bits[NCH-1-n]
             && !(a_we && a_addr == ADDR_W'(CTRL_IDX) && a_gir_bits[NCH-1-n]))
            |=> !b_pend[n]);
    end
endmodule

bind mbx_top mbx_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_we(a_we),
    .a_gir_bits(a_wdata[19:16]), .a_ovr(a_ovr), .b_addr(b_addr),
    .b_we(b_we), .b_re(b_re), .b_ack_bits(b_wdata[19:16]),
    .ab_full(ab_full), .b_pend(b_pend));

// File: tb/mbx_top_test.sv
module mbx_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  a_addr = '0, b_addr = '0;
    logic        a_we = 1'b0, a_re = 1'b0, b_we = 1'b0, b_re = 1'b0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, a_ovr, b_irq, b_ovr;
    int          checks = 0;
    int          fails = 0;
    logic [31:0] ra, rb;

    always #4 clk = ~clk;

    mbx_top uut (.*);

    typedef struct packed {
        logic        side;  // 0 = A, 1 = B
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 4'd8, 32'h0, 32'h00F00000},        // R1
        '{1'b0, 1'b0, 4'd9, 32'h0, 32'h00000000},        // R1
        '{1'b1, 1'b0, 4'd8, 32'h0, 32'h00F00000},        // R1
        '{1'b0, 1'b1, 4'd0, 32'h11111111, 32'h0},        // R2
        '{1'b1, 1'b0, 4'd8, 32'h0, 32'h08F00000},        // R2
        '{1'b0, 1'b0, 4'd8, 32'h0, 32'h00700000},        // R2
        '{1'b1, 1'b0, 4'd4, 32'h0, 32'h11111111},        // R3
        '{1'b0, 1'b0, 4'd8, 32'h0, 32'h00F00000},        // R3
        '{1'b1, 1'b0, 4'd8, 32'h0, 32'h00F00000},        // R3
        '{1'b1, 1'b1, 4'd3, 32'hCAFEF00D, 32'h0},        // R4
        '{1'b0, 1'b0, 4'd8, 32'h0, 32'h01F00000},        // R4
        '{1'b1, 1'b0, 4'd8, 32'h0, 32'h00E00000},        // R4
        '{1'b0, 1'b0, 4'd7, 32'h0, 32'hCAFEF00D},        // R4
        '{1'b0, 1'b0, 4'd8, 32'h0, 32'h00F00000},        // R4
        '{1'b0, 1'b1, 4'd9, 32'hF0F00005, 32'h0},        // R5
        '{1'b0, 1'b0, 4'd9, 32'h0, 32'hF0F00005},        // R5
        '{1'b1, 1'b0, 4'd9, 32'h0, 32'h00000000},        // R5
        '{1'b0, 1'b1, 4'd9, 32'h0, 32'h0},               // R5
        '{1'b0, 1'b0, 4'd1, 32'h0, 32'h00000000},        // R11
        '{1'b1, 1'b1, 4'd6, 32'h00000005, 32'h0},        // R11
        '{1'b1, 1'b0, 4'd6, 32'h0, 32'h00000000},        // R11
        '{1'b1, 1'b0, 4'd8, 32'h0, 32'h00F00000},        // R11
        '{1'b0, 1'b1, 4'd8, 32'hFFFFFFFF, 32'h0},        // R11
        '{1'b0, 1'b0, 4'd8, 32'h0, 32'h00F00000}         // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle on both sides; read data sampled before the edge
    task automatic cyc(input logic awe, input logic are, input logic [3:0] aad,
                       input logic [31:0] awd, input logic bwe, input logic bre,
                       input logic [3:0] bad, input logic [31:0] bwd,
                       output logic [31:0] ard, output logic [31:0] brd);
        @(negedge clk);
        a_we = awe; a_re = are; a_addr = aad; a_wdata = awd;
        b_we = bwe; b_re = bre; b_addr = bad; b_wdata = bwd;
        #1;
        ard = a_rdata;
        brd = b_rdata;
        @(posedge clk);
        #1;
        a_we = 1'b0; a_re = 1'b0; b_we = 1'b0; b_re = 1'b0;
    endtask

    task automatic wa(input logic [3:0] ad, input logic [31:0] d);
        logic [31:0] x, y;
        cyc(1'b1, 1'b0, ad, d, 1'b0, 1'b0, 4'd0, 32'h0, x, y);
    endtask
    task automatic wb(input logic [3:0] ad, input logic [31:0] d);
        logic [31:0] x, y;
        cyc(1'b0, 1'b0, 4'd0, 32'h0, 1'b1, 1'b0, ad, d, x, y);
    endtask
    task automatic rda(input logic [3:0] ad, output logic [31:0] r);
        logic [31:0] y;
        cyc(1'b0, 1'b1, ad, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, r, y);
    endtask
    task automatic rdb(input logic [3:0] ad, output logic [31:0] r);
        logic [31:0] x;
        cyc(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 1'b1, ad, 32'h0, x, r);
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 a_irq", {31'd0, a_irq}, 32'd0);
        chk("R1 a_ovr", {31'd0, a_ovr}, 32'd0);
        chk("R1 b_irq", {31'd0, b_irq}, 32'd0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) begin
                if (VEC[i].side) wb(VEC[i].addr, VEC[i].data);
                else             wa(VEC[i].addr, VEC[i].data);
            end else begin
                if (VEC[i].side) rdb(VEC[i].addr, ra);
                else             rda(VEC[i].addr, ra);
                chk($sformatf("vector %0d", i), ra, VEC[i].exp);
            end
        end

        // R7 receive source
        wa(4'd9, 32'h04000000);
        chk("R7 rie idle", {31'd0, a_irq}, 32'd0);
        wb(4'd1, 32'h0000ABCD);
        chk("R7 rie full", {31'd0, a_irq}, 32'd1);
        chk("R7 b quiet", {31'd0, b_irq}, 32'd0);
        rda(4'd5, ra);
        chk("R3 rx1 data", ra, 32'h0000ABCD);
        chk("R7 rie drained", {31'd0, a_irq}, 32'd0);
        // R7 transmit source
        wa(4'd9, 32'h00200000);
        chk("R7 tie empty", {31'd0, a_irq}, 32'd1);
        wa(4'd2, 32'h00000007);
        chk("R7 tie busy", {31'd0, a_irq}, 32'd0);
        rdb(4'd6, rb);
        chk("R2 tx2 data", rb, 32'h00000007);
        chk("R7 tie again", {31'd0, a_irq}, 32'd1);
        wa(4'd9, 32'h0);

        // R6 doorbell raise and acknowledge
        wa(4'd9, 32'h80000000);
        wb(4'd9, 32'h00080000);
        chk("R6 bell irq", {31'd0, a_irq}, 32'd1);
        rda(4'd8, ra);
        chk("R6 a status", ra, 32'h00F80000);
        rdb(4'd9, rb);
        chk("R5 gir readback", rb, 32'h00080000);
        wa(4'd8, 32'h00000000);
        rda(4'd8, ra);
        chk("R6 zero write ignored", ra, 32'h00F80000);
        wa(4'd8, 32'h00080000);
        rda(4'd8, ra);
        chk("R6 acked", ra, 32'h00F00000);
        chk("R6 irq low", {31'd0, a_irq}, 32'd0);
        rdb(4'd9, rb);
        chk("R6 gir cleared", rb, 32'h00000000);

        // R10 raise and acknowledge in one cycle
        cyc(1'b1, 1'b0, 4'd8, 32'h00080000, 1'b1, 1'b0, 4'd9, 32'h00080000, ra, rb);
        rda(4'd8, ra);
        chk("R10 set wins", ra, 32'h00F80000);
        wa(4'd8, 32'h00080000);
        wa(4'd9, 32'h0);

        // R9 write and read of one slot in one cycle
        wa(4'd1, 32'h00001111);
        cyc(1'b1, 1'b0, 4'd1, 32'h00002222, 1'b0, 1'b1, 4'd5, 32'h0, ra, rb);
        chk("R9 old data", rb, 32'h00001111);
        chk("R9 no overrun", {31'd0, a_ovr}, 32'd0);
        rdb(4'd8, rb);
        chk("R9 still full", rb, 32'h04F00000);
        rdb(4'd5, rb);
        chk("R9 new data", rb, 32'h00002222);

        // R8 overrun
        wa(4'd0, 32'h0000AAAA);
        wa(4'd0, 32'h0000BBBB);
        chk("R8 a_ovr set", {31'd0, a_ovr}, 32'd1);
        chk("R8 b_ovr clear", {31'd0, b_ovr}, 32'd0);
        rdb(4'd4, rb);
        chk("R8 overwritten", rb, 32'h0000BBBB);
        repeat (3) @(posedge clk);
        #1;
        chk("R8 sticky", {31'd0, a_ovr}, 32'd1);
        rdb(4'd8, rb);
        chk("R8 drained", rb, 32'h00F00000);

        // R1 reset in mid-run
        wa(4'd3, 32'h12345678);
        wa(4'd9, 32'h00000007);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R1 ovr cleared", {31'd0, a_ovr}, 32'd0);
        chk("R1 irq cleared", {31'd0, a_irq}, 32'd0);
        rda(4'd9, ra);
        chk("R1 ctrl cleared", ra, 32'h0);
        rdb(4'd8, rb);
        chk("R1 b status", rb, 32'h00F00000);
        rdb(4'd7, rb);
        chk("R1 rx data cleared", rb, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule